// File: doc/BRIEF.md
# Double-Buffered Command-Stream DMA Register Front End

This block is the host-visible register front end of a command-stream DMA. A host programs a buffer window (a start address and an exclusive end address) over a small register bus. The block turns those writes into a window for a separate fetch engine and tracks how far the engine has got. It holds one active transfer and one queued transfer. Writing the end register does one of two things, chosen by the start-pending flag: it extends the active window in place, or it launches or queues a transfer that begins at the latched start.

The fetch engine sees the active window as `winCur` and `winEnd`. It signals each 8-byte command word it has consumed with `fetchWord`, and the block advances its current pointer by one word. A one-cycle `launch` strobe marks every new window. Freeze pauses progress. Flush drops all work. The source-select bit is held here for the engine to use.

Top module: `cmd_dma_frontend`

## Requirements
- R1: Addresses are 24 bits. The start register sits at offset 0x0, end at 0x4, current at 0x8 (read-only) and status at 0xC. The low 3 bits of written start and end values are dropped and read back as zero.
- R2: A start write sets status bit 10 (start pending) and launches nothing.
- R3: An end write while bit 10 is set and nothing is running launches the window from start to end. It pulses `launch` for one cycle and clears bit 10 in that same cycle.
- R4: Each `fetchWord` during an active, unfrozen transfer moves current up by 8. Status bit 8 (busy) is set while current differs from the active end, and the transfer finishes with current equal to the end.
- R5: An end write while bit 10 is clear moves the active end to the new value, whether the transfer is running or has finished. It gives no launch strobe.
- R6: Start equal to end launches a zero-byte transfer that is not busy, and a later end write can extend it.
- R7: An end write while bit 10 is set and a transfer is running sets bit 9 (end pending). Start and end reads return the queued values. Further end writes change only the queued end, and the active window stays as it was.
- R8: When the active transfer completes with a queued one present, the queued window becomes active with a launch strobe, and bits 10 and 9 clear in that same cycle.
- R9: While status bit 1 (freeze) is set, current does not move and no transfer launches. Start and end writes still set the pending flags.
- R10: While status bit 2 (flush) is set, the active transfer and any queued one are dropped: busy, bit 10 and bit 9 read 0.
- R11: Status writes use set/clear pairs: flush at bits 5/4, freeze at bits 3/2, source select (status bit 0) at bits 1/0. Writing both bits of a pair leaves the bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| fetchWord | input | 1 | Fetch engine consumed one 8-byte word |
| winCur | output | 24 | Active window current pointer |
| winEnd | output | 24 | Active window end (exclusive) |
| launch | output | 1 | One-cycle strobe when a new window becomes active |
| dmaBusy | output | 1 | Active window not yet exhausted |
| freezeOn | output | 1 | Freeze control |
| flushOn | output | 1 | Flush control |
| srcSel | output | 1 | Source select |

## Verification
The hardest state to reach is a queued transfer that must wait past a freeze and then be promoted when the active window drains. The bench reaches it with a directed sequence. It opens a transfer and sets freeze. It queues a start and an end behind the frozen transfer and checks that fetch pulses do not move the pointer. It then releases freeze, issues exactly enough fetch pulses to drain the active window, and checks the launch strobe, the flag clearing and the promoted window in the cycle after the last word. Flush is applied the same way, with a queued start present while a transfer is running.

// File: rtl/cmd_dma_pkg.sv
package cmd_dma_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] OFS_START = 4'h0;
  localparam logic [REG_AW-1:0] OFS_END   = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CUR   = 4'h8;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'hC;

  typedef struct packed {
    logic ldStart;
    logic ldEnd;
    logic extend;
    logic launchBus;
    logic promote;
    logic advance;
    logic drop;
  } dpStrobe_t;
endpackage

// File: rtl/cmd_dma_datapath.sv
module cmd_dma_datapath
  import cmd_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ALIGN  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REG_AW-1:0] rdAddr,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] actEnd,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;
  localparam logic [ADDR_W-1:0] MASK = {{(ADDR_W-ALIGN){1'b1}}, {ALIGN{1'b0}}};

  logic [ADDR_W-1:0] startReg, endReg, wa;

  assign wa   = wrData[ADDR_W-1:0] & MASK;
  assign busy = (curAddr != actEnd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      endReg   <= '0;
      curAddr  <= '0;
      actEnd   <= '0;
    end else begin
      if (stb.ldStart) startReg <= wa;
      if (stb.ldEnd)   endReg   <= wa;
      if (stb.launchBus) begin
        curAddr <= startReg;
        actEnd  <= wa;
      end else if (stb.promote) begin
        curAddr <= startReg;
        actEnd  <= endReg;
      end else begin
        if (stb.advance) curAddr <= curAddr + STEP;
        if (stb.drop)        actEnd <= curAddr;
        else if (stb.extend) actEnd <= wa;
      end
    end
  end

  always_comb begin
    unique case (rdAddr)
      OFS_START: rdData = {{(DATA_W-ADDR_W){1'b0}}, startReg};
      OFS_END:   rdData = {{(DATA_W-ADDR_W){1'b0}}, endReg};
      OFS_CUR:   rdData = {{(DATA_W-ADDR_W){1'b0}}, curAddr};
      OFS_STAT:  rdData = statusWord;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/cmd_dma_control.sv
module cmd_dma_control
  import cmd_dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              fetchWord,
  input  logic              busy,
  output dpStrobe_t         stb,
  output logic [DATA_W-1:0] statusWord,
  output logic              startPend,
  output logic              endPend,
  output logic              freezeOn,
  output logic              flushOn,
  output logic              srcSel,
  output logic              launch
);
  logic wrStart, wrEnd, wrStat, halted;

  function automatic logic pairUpd(logic cur, logic setB, logic clrB);
    if (setB && !clrB)      return 1'b1;
    else if (clrB && !setB) return 1'b0;
    else                    return cur;
  endfunction

  assign wrStart = regWrEn && (regAddr == OFS_START);
  assign wrEnd   = regWrEn && (regAddr == OFS_END);
  assign wrStat  = regWrEn && (regAddr == OFS_STAT);
  assign halted  = freezeOn || flushOn;

  always_comb begin
    stb           = '0;
    stb.ldStart   = wrStart;
    stb.ldEnd     = wrEnd;
    stb.drop      = flushOn;
    stb.advance   = fetchWord && busy && !halted;
    stb.launchBus = wrEnd && startPend && !endPend && !busy && !halted;
    stb.promote   = endPend && !busy && !halted && !wrEnd && !wrStart;
    stb.extend    = wrEnd && !startPend && !flushOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPend <= 1'b0;
      endPend   <= 1'b0;
      freezeOn  <= 1'b0;
      flushOn   <= 1'b0;
      srcSel    <= 1'b0;
      launch    <= 1'b0;
    end else begin
      launch <= stb.launchBus || stb.promote;
      if (flushOn || stb.launchBus || stb.promote) begin
        startPend <= 1'b0;
        endPend   <= 1'b0;
      end else begin
        if (wrStart)              startPend <= 1'b1;
        if (wrEnd && startPend)   endPend   <= 1'b1;
      end
      if (wrStat) begin
        flushOn  <= pairUpd(flushOn,  regWrData[5], regWrData[4]);
        freezeOn <= pairUpd(freezeOn, regWrData[3], regWrData[2]);
        srcSel   <= pairUpd(srcSel,   regWrData[1], regWrData[0]);
      end
    end
  end

  always_comb begin
    statusWord     = '0;
    statusWord[10] = startPend;
    statusWord[9]  = endPend;
    statusWord[8]  = busy;
    statusWord[2]  = flushOn;
    statusWord[1]  = freezeOn;
    statusWord[0]  = srcSel;
  end
endmodule

// File: rtl/cmd_dma_frontend.sv
module cmd_dma_frontend
  import cmd_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ALIGN  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              fetchWord,
  output logic [ADDR_W-1:0] winCur,
  output logic [ADDR_W-1:0] winEnd,
  output logic              launch,
  output logic              dmaBusy,
  output logic              freezeOn,
  output logic              flushOn,
  output logic              srcSel
);
  dpStrobe_t         stb;
  logic [DATA_W-1:0] statusWord;
  logic              startPend, endPend;

  cmd_dma_control #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .fetchWord(fetchWord), .busy(dmaBusy),
    .stb(stb), .statusWord(statusWord), .startPend(startPend),
    .endPend(endPend), .freezeOn(freezeOn), .flushOn(flushOn),
    .srcSel(srcSel), .launch(launch)
  );

  cmd_dma_datapath #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .rdAddr(regAddr), .statusWord(statusWord), .rdData(regRdData),
    .curAddr(winCur), .actEnd(winEnd), .busy(dmaBusy)
  );
endmodule

// File: rtl/cmd_dma_checker.sv
module cmd_dma_checker #(
  parameter int ADDR_W = 24,
  parameter int ALIGN  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] winCur,
  input logic [ADDR_W-1:0] winEnd,
  input logic              launch,
  input logic              dmaBusy,
  input logic              freezeOn,
  input logic              flushOn,
  input logic              startPend,
  input logic              endPend
);
  a_r1_cur_aligned: assert property (@(posedge clk) disable iff (!rstN)
    winCur[ALIGN-1:0] == '0);

  a_r8_launch_clears_flags: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> (!startPend && !endPend));

  a_r7_endpend_has_start: assert property (@(posedge clk) disable iff (!rstN)
    endPend |-> startPend);

  a_r9_freeze_holds_cur: assert property (@(posedge clk) disable iff (!rstN)
    freezeOn |=> $stable(winCur));

  a_r9_freeze_no_launch: assert property (@(posedge clk) disable iff (!rstN)
    (freezeOn && !flushOn) |=> !launch);

  a_r10_flush_drops: assert property (@(posedge clk) disable iff (!rstN)
    flushOn |=> (!dmaBusy && !startPend && !endPend && (winCur == winEnd)));
endmodule

bind cmd_dma_frontend cmd_dma_checker #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_chk (
  .clk(clk), .rstN(rstN), .winCur(winCur), .winEnd(winEnd), .launch(launch),
  .dmaBusy(dmaBusy), .freezeOn(freezeOn), .flushOn(flushOn),
  .startPend(startPend), .endPend(endPend)
);

// File: tb/cmd_dma_frontend_test.sv
module cmd_dma_frontend_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        fetchWord;
  logic [23:0] winCur, winEnd;
  logic        launch, dmaBusy, freezeOn, flushOn, srcSel;
  int          testCount = 0;
  int          failCount = 0;

  always #4 clk = ~clk;

  cmd_dma_frontend uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .fetchWord(fetchWord),
    .winCur(winCur), .winEnd(winEnd), .launch(launch), .dmaBusy(dmaBusy),
    .freezeOn(freezeOn), .flushOn(flushOn), .srcSel(srcSel)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic fetch(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fetchWord = 1'b1;
      @(negedge clk); fetchWord = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'hC, d); check("R1 reset status", d, 32'h0);
    rd(4'h8, d); check("R1 reset current", d, 32'h0);
  endtask

  task automatic t_align_start;
    logic [31:0] d;
    wr(4'h0, 32'hFF12_3457);
    check("R2 no launch on start write", {31'b0, launch}, 32'h0);
    rd(4'h0, d); check("R1 start low bits dropped", d, 32'h0012_3450);
    rd(4'hC, d); check("R2 start pending set", d, 32'h400);
  endtask

  task automatic t_launch_and_run;
    logic [31:0] d;
    wr(4'h0, 32'h100);
    wr(4'h4, 32'h127);
    check("R3 launch strobe", {31'b0, launch}, 32'h1);
    check("R3 window cur", {8'b0, winCur}, 32'h100);
    check("R1 end aligned", {8'b0, winEnd}, 32'h120);
    rd(4'hC, d); check("R3 pending cleared busy set", d, 32'h100);
    check("R3 launch one cycle", {31'b0, launch}, 32'h0);
    fetch(3);
    rd(4'h8, d); check("R4 current after 3 words", d, 32'h118);
    fetch(1);
    rd(4'hC, d); check("R4 done not busy", d, 32'h0);
    check("R4 current equals end", {8'b0, winCur}, 32'h120);
  endtask

  task automatic t_incremental;
    logic [31:0] d;
    wr(4'h4, 32'h130);
    check("R5 no launch on extend", {31'b0, launch}, 32'h0);
    check("R5 end moved", {8'b0, winEnd}, 32'h130);
    check("R5 current kept", {8'b0, winCur}, 32'h120);
    rd(4'hC, d); check("R5 resumed busy", d, 32'h100);
    fetch(2);
    check("R5 drained", {31'b0, dmaBusy}, 32'h0);
  endtask

  task automatic t_zero_byte;
    logic [31:0] d;
    wr(4'h0, 32'h200);
    wr(4'h4, 32'h200);
    check("R6 zero-byte launch", {31'b0, launch}, 32'h1);
    check("R6 zero-byte idle", {31'b0, dmaBusy}, 32'h0);
    wr(4'h4, 32'h208);
    check("R6 extend no launch", {31'b0, launch}, 32'h0);
    rd(4'hC, d); check("R6 extended busy", d, 32'h100);
  endtask

  task automatic t_queue_promote;
    logic [31:0] d;
    wr(4'h0, 32'h300);
    wr(4'h4, 32'h310);
    check("R7 no launch while busy", {31'b0, launch}, 32'h0);
    rd(4'hC, d); check("R7 both pending", d, 32'h700);
    rd(4'h0, d); check("R7 start reads queued", d, 32'h300);
    wr(4'h4, 32'h318);
    rd(4'h4, d); check("R7 end reads queued", d, 32'h318);
    check("R7 active end kept", {8'b0, winEnd}, 32'h208);
    fetch(1);
    @(negedge clk);
    check("R8 promote launch", {31'b0, launch}, 32'h1);
    check("R8 promoted cur", {8'b0, winCur}, 32'h300);
    check("R8 promoted end", {8'b0, winEnd}, 32'h318);
    #1 regAddr = 4'hC;
    #1 check("R8 flags cleared", regRdData, 32'h100);
  endtask

  task automatic t_freeze;
    logic [31:0] d;
    wr(4'hC, 32'h8);
    rd(4'hC, d); check("R9 freeze bit", d, 32'h102);
    fetch(2);
    check("R9 current held", {8'b0, winCur}, 32'h300);
    wr(4'h0, 32'h400);
    wr(4'h4, 32'h408);
    rd(4'hC, d); check("R9 flags set while frozen", d, 32'h702);
    wr(4'hC, 32'h4);
    fetch(3);
    @(negedge clk);
    check("R9 launch after thaw", {31'b0, launch}, 32'h1);
    check("R9 queued cur", {8'b0, winCur}, 32'h400);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    wr(4'h0, 32'h500);
    wr(4'hC, 32'h20);
    rd(4'hC, d); check("R10 flush dropped all", d, 32'h4);
    wr(4'hC, 32'h10);
    rd(4'hC, d); check("R10 flush cleared", d, 32'h0);
    wr(4'h0, 32'h600);
    wr(4'h4, 32'h608);
    check("R10 fresh launch after flush", {31'b0, launch}, 32'h1);
    check("R10 fresh cur", {8'b0, winCur}, 32'h600);
  endtask

  task automatic t_pairs;
    logic [31:0] d;
    wr(4'hC, 32'h2);
    rd(4'hC, d); check("R11 source set", d & 32'h7, 32'h1);
    wr(4'hC, 32'h3);
    rd(4'hC, d); check("R11 both source bits keep", d & 32'h7, 32'h1);
    wr(4'hC, 32'hC);
    rd(4'hC, d); check("R11 both freeze bits keep", d & 32'h7, 32'h1);
    wr(4'hC, 32'h1);
    rd(4'hC, d); check("R11 source clear", d & 32'h7, 32'h0);
  endtask

  initial begin
    #1_000_000;
    failCount++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0; fetchWord = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_align_start();
    t_launch_and_run();
    t_incremental();
    t_zero_byte();
    t_queue_promote();
    t_freeze();
    t_flush();
    t_pairs();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule